// File: doc/BRIEF.md
# Glitch-Free Selectable Clock Divider

The block takes a fast input clock and produces a divided clock whose ratio is chosen by a 2-bit code. The available ratios are 1, 2, 4 and 8. The outputs are a true and a complementary version of the divided clock. The code mapping is not monotonic: code `00` selects divide by 2, `01` divide by 4, `10` divide by 8 and `11` passes the input clock through. At every ratio the output spends half of its period high and half low.

An active-high output enable gates the divided clock. The enable is first brought into the input clock domain through a short flop chain. It then changes the output only while the selected output is low, so turning the output on or off never shortens a high pulse. While disabled, the true output rests low and the complementary output rests high.

The ratio code is meant to be quasi-static. When it changes, the internal counter restarts on the first clock edge that sees the new code. From that edge the new ratio runs with a clean phase. The only pulse that may be cut short is the one in progress at the switch.

Top module: `clkDivTop`

## Requirements
- R1: The output period equals the selected ratio in input clock cycles: code 00 gives 2, code 01 gives 4, code 10 gives 8, code 11 gives 1.
- R2: The output duty cycle is 50% at every ratio. For ratios 2, 4 and 8 the output is high for ratio/2 input cycles. At ratio 1 it is high exactly while the input clock is high.
- R3: A new code is acted on at the first rising input edge that sees it. At that edge the output goes low. For ratios 2, 4 and 8 the first rise comes ratio/2 cycles later; at ratio 1 the output follows the clock from that edge.
- R4: The enable changes the output only while the output is low, so every high pulse has its full ratio-defined width while the enable toggles.
- R5: The enable is active high and passes through SYNC_STAGES flops. Once disabled, the true output stays low and the complementary output stays high. After re-enabling, full pulses resume.
- R6: The complementary output is always the inverse of the true output.
- R7: While reset is asserted, the true output is low and the complementary output is high. After release, the counter counts up from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock to be divided |
| rstN | input | 1 | Asynchronous reset, active low |
| divCode | input | 2 | Ratio select: 00 /2, 01 /4, 10 /8, 11 /1 |
| outEn | input | 1 | Output enable, active high, asynchronous to clk |
| clkOutP | output | 1 | Divided clock, true polarity |
| clkOutN | output | 1 | Divided clock, complementary polarity |

## Verification
Two kinds of fault show up at the ports. A counter that skips or fails to restart shows up as a wrong period or an uneven high/low split, at the latest within one full output period of eight input cycles. A gate register that loads at the wrong moment shows up as a high pulse shorter than its ratio-defined width, on the first enable or disable toggle that lands while the output is high. The bench measures every pulse in half-cycle units. It compares each pulse with the width the selected ratio implies, and it also times the first rise after each code change.

// File: rtl/divPkg.sv
package divPkg;
  localparam int CODE_W    = 2;
  localparam int MAX_RATIO = 8;
  localparam int CNT_W     = $clog2(MAX_RATIO);

  // Ratio codes; the code-to-ratio order is part of the external contract
  typedef enum logic [CODE_W-1:0] {
    CODE_DIV2 = 2'b00,
    CODE_DIV4 = 2'b01,
    CODE_DIV8 = 2'b10,
    CODE_DIV1 = 2'b11
  } divCode_e;

  // Strobes passed from control to datapath
  typedef struct packed {
    logic     restart;
    logic     enReq;
    divCode_e code;
  } divStrobe_t;
endpackage

// File: rtl/divCtrl.sv
module divCtrl import divPkg::*; #(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] codeIn,
  input  logic              enIn,
  output divStrobe_t        strobe
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncQ;
  divCode_e               codeQ;
  logic                   codeDiff;

  // Enable synchroniser chain
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], enIn};
  end

  // Held ratio code; a mismatch with the input restarts the counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) codeQ <= CODE_DIV2;
    else       codeQ <= divCode_e'(codeIn);
  end

  assign codeDiff = (divCode_e'(codeIn) != codeQ);

  always_comb begin
    strobe.restart = codeDiff;
    strobe.enReq   = syncQ[LAST];
    strobe.code    = codeQ;
  end
endmodule

// File: rtl/divPath.sv
module divPath import divPkg::*; (
  input  logic             clk,
  input  logic             rstN,
  input  divStrobe_t       strobe,
  output logic             outP,
  output logic             outN,
  output logic [CNT_W-1:0] cntVal,
  output logic             gateVal,
  output logic             tapVal
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] nextCnt;
  logic             nextTap;
  logic             enGate;
  logic             enLow;
  logic             bypass;

  function automatic logic pickTap(input logic [CNT_W-1:0] v, input divCode_e c);
    case (c)
      CODE_DIV2: return v[0];
      CODE_DIV4: return v[1];
      CODE_DIV8: return v[2];
      default:   return 1'b0;
    endcase
  endfunction

  assign nextCnt = strobe.restart ? '0 : cnt + CNT_W'(1);
  assign nextTap = pickTap(nextCnt, strobe.code);
  assign tapVal  = pickTap(cnt, strobe.code);
  assign bypass  = (strobe.code == CODE_DIV1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cnt <= '0;
    else       cnt <= nextCnt;
  end

  // Divided modes: the gate may move only on an edge after which the tap is low
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         enGate <= 1'b0;
    else if (!nextTap) enGate <= strobe.enReq;
  end

  // Bypass mode: the gate moves on the falling edge, during the low phase
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) enLow <= 1'b0;
    else       enLow <= strobe.enReq;
  end

  assign outP    = bypass ? (clk & enLow) : (tapVal & enGate);
  assign outN    = ~outP;
  assign cntVal  = cnt;
  assign gateVal = enGate;
endmodule

// File: rtl/clkDivTop.sv
module clkDivTop import divPkg::*; #(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] divCode,
  input  logic              outEn,
  output logic              clkOutP,
  output logic              clkOutN
);
  divStrobe_t       strobe;
  logic [CNT_W-1:0] cntVal;
  logic             gateVal;
  logic             tapVal;

  divCtrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .codeIn (divCode),
    .enIn   (outEn),
    .strobe (strobe)
  );

  divPath u_path (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .outP    (clkOutP),
    .outN    (clkOutN),
    .cntVal  (cntVal),
    .gateVal (gateVal),
    .tapVal  (tapVal)
  );
endmodule

// File: rtl/clkDivTop_chk.sv
module clkDivTop_chk import divPkg::*; (
  input logic             clk,
  input logic             rstN,
  input divStrobe_t       strobe,
  input logic [CNT_W-1:0] cntVal,
  input logic             gateVal,
  input logic             tapVal
);
  // R1: the counter steps by one on every edge that is not a restart
  a_r1_count_step: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(strobe.restart)) |-> (cntVal == CNT_W'($past(cntVal) + CNT_W'(1))));

  // R3: a code change lands with the counter cleared
  a_r3_restart_zero: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.code != $past(strobe.code)) |-> (cntVal == '0));

  // R4: the divided-mode gate changes only with the selected tap low
  a_r4_gate_when_low: assert property (@(posedge clk) disable iff (!rstN)
    (gateVal != $past(gateVal)) |-> !tapVal);

  // R5: the gate opens only after a synchronised request
  a_r5_gate_rise_req: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gateVal) |-> $past(strobe.enReq));

  // R5: the gate closes only after the synchronised request drops
  a_r5_gate_fall_req: assert property (@(posedge clk) disable iff (!rstN)
    $fell(gateVal) |-> !$past(strobe.enReq));
endmodule

bind clkDivTop clkDivTop_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .strobe  (strobe),
  .cntVal  (cntVal),
  .gateVal (gateVal),
  .tapVal  (tapVal)
);

// File: tb/clkDivTop_tb.sv
module clkDivTop_tb;
  typedef struct { int hi; int lo; } pulse_t;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] code = 2'b00;
  logic       en = 1'b1;
  logic       outP;
  logic       outN;

  int checks = 0;
  int fails  = 0;

  pulse_t expQ[$];
  event   riseEv;
  logic   prevP = 1'b0;
  logic   started = 1'b0;
  int     hiRun = 0;
  int     loRun = 0;
  logic   runtMode = 1'b0;
  int     runtExp = 0;

  always #10 clk = ~clk;

  clkDivTop u_dut (
    .clk     (clk),
    .rstN    (rstN),
    .divCode (code),
    .outEn   (en),
    .clkOutP (outP),
    .clkOutN (outN)
  );

  function automatic int ratioOf(input logic [1:0] c);
    case (c)
      2'b00: return 2;
      2'b01: return 4;
      2'b10: return 8;
      default: return 1;
    endcase
  endfunction

  // Monitor: one sample per half cycle, away from both clock edges
  task automatic sampleIt();
    pulse_t e;
    checks++;
    if (outN !== ~outP) begin
      fails++;
      $display("FAIL R6 complement: outP=%b outN=%b expected outN=%b", outP, outN, ~outP);
    end
    if (outP && !prevP) begin
      if (started && expQ.size() > 0) begin
        e = expQ.pop_front();
        checks++;
        if (hiRun != e.hi || loRun != e.lo) begin
          fails++;
          $display("FAIL R1,R2 pulse shape: high=%0d low=%0d half-cycles, expected high=%0d low=%0d",
                   hiRun, loRun, e.hi, e.lo);
        end
      end
      started = 1'b1;
      hiRun = 1;
      loRun = 0;
      -> riseEv;
    end else if (!outP && prevP) begin
      if (runtMode) begin
        checks++;
        if (hiRun != runtExp) begin
          fails++;
          $display("FAIL R4 runt pulse: high=%0d half-cycles, expected %0d", hiRun, runtExp);
        end
      end
      loRun = 1;
    end else if (outP) begin
      hiRun++;
    end else begin
      loRun++;
    end
    prevP = outP;
  endtask

  initial begin
    forever begin
      @(posedge clk); #5; sampleIt();
      @(negedge clk); #5; sampleIt();
    end
  end

  // Driver: queue n full pulses of ratio r starting at the next rise
  task automatic expectPulses(input int r, input int n);
    pulse_t p;
    p.hi = r;
    p.lo = r;
    @(riseEv);
    for (int i = 0; i < n; i++) expQ.push_back(p);
    while (expQ.size() != 0) @(posedge clk);
  endtask

  // R3: switch code and time the first rise after the switch edge
  task automatic switchCode(input logic [1:0] c);
    int k;
    int expK;
    logic seen;
    @(negedge clk);
    code = c;
    expK = (ratioOf(c) == 1) ? 1 : ratioOf(c) / 2 + 1;
    k = 0;
    seen = 1'b0;
    for (int i = 0; i < 20; i++) begin
      if (!seen) begin
        @(posedge clk); #5;
        k++;
        if (outP) seen = 1'b1;
      end
    end
    checks++;
    if (!seen || k != expK) begin
      fails++;
      $display("FAIL R3 first rise after code %b: at edge %0d, expected edge %0d", c, k, expK);
    end
  endtask

  // R5: output held at rest while disabled
  task automatic checkDisabled(input int halfs);
    for (int i = 0; i < halfs; i++) begin
      @(posedge clk); #7;
      checks++;
      if (outP !== 1'b0 || outN !== 1'b1) begin
        fails++;
        $display("FAIL R5 disabled rest: outP=%b outN=%b, expected 0 1", outP, outN);
      end
    end
  endtask

  // R4: toggle the enable at varied offsets and watch for short highs
  task automatic toggleEnable(input int r);
    runtExp = r;
    runtMode = 1'b1;
    for (int i = 0; i < 6; i++) begin
      repeat (i + 3) @(negedge clk);
      en = 1'b0;
      repeat (i + 5) @(negedge clk);
      en = 1'b1;
    end
    repeat (20) @(posedge clk);
    runtMode = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #7;
    // R7: reset state
    checks++;
    if (outP !== 1'b0 || outN !== 1'b1) begin
      fails++;
      $display("FAIL R7 reset outputs: outP=%b outN=%b, expected 0 1", outP, outN);
    end
    @(negedge clk);
    rstN = 1'b1;

    // R7 and R1: divide by 2 runs cleanly from reset
    repeat (6) @(posedge clk);
    expectPulses(2, 4);

    // R1, R2, R3: each code in turn, including non-monotonic order
    switchCode(2'b01); expectPulses(4, 4);
    switchCode(2'b10); expectPulses(8, 3);
    switchCode(2'b11); expectPulses(1, 8);
    switchCode(2'b00); expectPulses(2, 4);
    switchCode(2'b10); expectPulses(8, 3);
    switchCode(2'b11); expectPulses(1, 6);
    switchCode(2'b01); expectPulses(4, 4);

    // R4: enable toggling never shortens a high pulse
    switchCode(2'b10); toggleEnable(8); expectPulses(8, 2);
    switchCode(2'b00); toggleEnable(2); expectPulses(2, 4);
    switchCode(2'b11); toggleEnable(1); expectPulses(1, 6);
    switchCode(2'b01); toggleEnable(4); expectPulses(4, 3);

    // R5: disable holds outputs at rest, re-enable restores pulses
    switchCode(2'b10);
    @(negedge clk); en = 1'b0;
    repeat (16) @(posedge clk);
    checkDisabled(24);
    @(negedge clk); en = 1'b1;
    repeat (16) @(posedge clk);
    expectPulses(8, 2);

    switchCode(2'b11);
    @(negedge clk); en = 1'b0;
    repeat (8) @(posedge clk);
    checkDisabled(16);
    @(negedge clk); en = 1'b1;
    repeat (8) @(posedge clk);
    expectPulses(1, 6);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule